// File: doc/BRIEF.md
# Bit-Time Timestamp Timer

This block keeps a free-running count of bus bit times for a CAN controller. A one-cycle tick marks the end of each nominal bit time, and the count advances once per tick. The block then offers that count in three ways. First, it is a live value. Second, it is latched into a timestamp register at each frame boundary. Third, it is compared against one 16-bit timemark per mailbox, and the result raises match pulses that drive time-triggered transmission.

A two-state machine controls the counter. In `ST_RUN` the count advances on each tick. When freezing is disabled, a tick at the all-ones value wraps the count to zero and raises a one-cycle wrap pulse. When freezing is enabled, the same tick takes the transition `T_SATURATE` into `ST_FROZEN`. In that state the count holds at all-ones and the frozen flag stays high. Only a clear pulse leaves `ST_FROZEN`, through the transition `T_RELEASE`. A clear pulse in `ST_RUN` zeroes the count and stays in `ST_RUN`. Dropping the freeze enable while frozen has no effect.

A capture-point select chooses which frame boundary latches the timestamp: start of frame or end of frame. Timemark matches are produced only while time-triggered mode is on.

Top module: `tstamp_timer`

## Requirements
- R1: After reset the count, timestamp, frozen flag, wrap pulse and all match pulses are zero.
- R2: In `ST_RUN` the count rises by one on the clock edge that samples `bit_tick` high. Without a tick or clear it holds its value.
- R3: A high `clr_pulse` sets the count to zero on the next edge and returns the machine to `ST_RUN`. This overrides a tick in the same cycle and also applies from `ST_FROZEN`.
- R4: With `freeze_en` low, a tick at count 0xFFFF wraps the count to 0. `wrap_o` is high for exactly the one cycle in which `cnt_o` first shows that 0.
- R5: With `freeze_en` high, a tick at count 0xFFFF enters `ST_FROZEN`, and `frozen_o` goes high. The count then holds 0xFFFF despite further ticks, and even if `freeze_en` falls, until a clear arrives.
- R6: When `cap_at_eof` is 0, `sof_pulse` latches the count. When it is 1, `eof_pulse` latches it. The latched value is the count held just before that edge, and `stamp_o` shows it from the next cycle. The pulse that is not selected leaves `stamp_o` unchanged.
- R7: With `tt_mode` high, mailbox i's bit of `mark_hit_o` (mark in bits [16i+15:16i] of `mark_vals`) is high for the one cycle in which `cnt_o` first shows a new value equal to that mark. A new value comes from a tick advance, a wrap or a clear.
- R8: With `tt_mode` low in the cycle before, `mark_hit_o` is all zero.
- R9: While the count is held (no tick, or `ST_FROZEN`), match pulses do not repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per completed bit time |
| sof_pulse | input | 1 | Start-of-frame pulse |
| eof_pulse | input | 1 | End-of-frame pulse |
| cap_at_eof | input | 1 | Capture point: 0 start of frame, 1 end of frame |
| freeze_en | input | 1 | Saturate at all-ones instead of wrapping |
| clr_pulse | input | 1 | Software timer clear |
| tt_mode | input | 1 | Time-triggered mode enables match pulses |
| mark_vals | input | 128 | Eight 16-bit timemarks, mailbox i in bits [16i+15:16i] |
| cnt_o | output | 16 | Current count |
| stamp_o | output | 16 | Latched timestamp |
| frozen_o | output | 1 | High in `ST_FROZEN` |
| wrap_o | output | 1 | One-cycle wrap pulse |
| mark_hit_o | output | 8 | Per-mailbox timemark match pulses |

## Verification
The assertions treat `bit_tick`, `clr_pulse`, `sof_pulse` and `eof_pulse` as synchronous, level-sampled inputs. Each is meaningful only in the cycle in which it is high, and none may change between clock edges. The stimulus changes every input on the falling clock edge only. It mixes random ticks, clears, frame pulses and mode changes with two long runs of back-to-back ticks that reach 0xFFFF, one with freezing enabled and one without. A clear is issued in the same cycle as a tick while frozen, to reach the priority corner.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
    localparam int TS_CNT_W = 16;
    localparam int TS_MB_N  = 8;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_FROZEN = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/tstamp_counter.sv
module tstamp_counter
    import tstamp_pkg::*;
#(
    parameter int CNT_W = TS_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic             freeze_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             cnt_upd,
    output logic             frozen,
    output logic             wrap_q
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    tmr_state_e state_q, state_d;
    logic       at_max;
    logic       wrap_d;

    assign at_max = (cnt_q == CNT_MAX);

    // next-state: T_SATURATE (run -> frozen), T_RELEASE (frozen -> run)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (!clr && tick && at_max && freeze_en) begin
                    state_d = ST_FROZEN;
                end
            end
            ST_FROZEN: begin
                if (clr) begin
                    state_d = ST_RUN;
                end
            end
        endcase
    end

    // counting datapath driven by the current state
    always_comb begin
        cnt_nxt = cnt_q;
        cnt_upd = 1'b0;
        wrap_d  = 1'b0;
        if (clr) begin
            cnt_nxt = CNT_ZERO;
            cnt_upd = 1'b1;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (tick) begin
                        if (!at_max) begin
                            cnt_nxt = cnt_q + 1'b1;
                            cnt_upd = 1'b1;
                        end else if (!freeze_en) begin
                            cnt_nxt = CNT_ZERO;
                            cnt_upd = 1'b1;
                            wrap_d  = 1'b1;
                        end
                    end
                end
                ST_FROZEN: begin
                    cnt_upd = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= CNT_ZERO;
            wrap_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt;
            wrap_q <= wrap_d;
        end
    end

    assign frozen = (state_q == ST_FROZEN);

    // R2
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt_q));
    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == CNT_ZERO) && !frozen);
    // R5
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !clr) |=> frozen && (cnt_q == CNT_MAX));
    // R4
    wrap_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |-> (cnt_q == CNT_ZERO) && !frozen);
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture
    import tstamp_pkg::*;
#(
    parameter int CNT_W = TS_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             eof,
    input  logic             at_eof,
    input  logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] stamp_q
);
    logic take;

    assign take = at_eof ? eof : sof;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stamp_q <= '0;
        end else if (take) begin
            stamp_q <= cnt_q;
        end
    end

    // R6
    no_event_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof && !eof) |=> $stable(stamp_q));
endmodule

// File: rtl/tstamp_compare.sv
module tstamp_compare
    import tstamp_pkg::*;
#(
    parameter int CNT_W = TS_CNT_W,
    parameter int MB_N  = TS_MB_N
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tt_mode,
    input  logic                  cnt_upd,
    input  logic [CNT_W-1:0]      cnt_nxt,
    input  logic [MB_N*CNT_W-1:0] marks,
    output logic [MB_N-1:0]       hit_q
);
    for (genvar i = 0; i < MB_N; i++) begin : g_mb
        logic eq;
        assign eq = (cnt_nxt == marks[i*CNT_W +: CNT_W]);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hit_q[i] <= 1'b0;
            end else begin
                hit_q[i] <= tt_mode && cnt_upd && eq;
            end
        end
    end

    // R8
    tt_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tt_mode |=> (hit_q == '0));
    // R9
    held_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_upd |=> (hit_q == '0));
endmodule

// File: rtl/tstamp_timer.sv
module tstamp_timer
    import tstamp_pkg::*;
#(
    parameter int CNT_W = TS_CNT_W,
    parameter int MB_N  = TS_MB_N
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_tick,
    input  logic                  sof_pulse,
    input  logic                  eof_pulse,
    input  logic                  cap_at_eof,
    input  logic                  freeze_en,
    input  logic                  clr_pulse,
    input  logic                  tt_mode,
    input  logic [MB_N*CNT_W-1:0] mark_vals,
    output logic [CNT_W-1:0]      cnt_o,
    output logic [CNT_W-1:0]      stamp_o,
    output logic                  frozen_o,
    output logic                  wrap_o,
    output logic [MB_N-1:0]       mark_hit_o
);
    logic [CNT_W-1:0] cnt_nxt;
    logic             cnt_upd;

    tstamp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .clr       (clr_pulse),
        .freeze_en (freeze_en),
        .cnt_q     (cnt_o),
        .cnt_nxt   (cnt_nxt),
        .cnt_upd   (cnt_upd),
        .frozen    (frozen_o),
        .wrap_q    (wrap_o)
    );

    tstamp_capture #(.CNT_W(CNT_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof     (sof_pulse),
        .eof     (eof_pulse),
        .at_eof  (cap_at_eof),
        .cnt_q   (cnt_o),
        .stamp_q (stamp_o)
    );

    tstamp_compare #(.CNT_W(CNT_W), .MB_N(MB_N)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tt_mode (tt_mode),
        .cnt_upd (cnt_upd),
        .cnt_nxt (cnt_nxt),
        .marks   (mark_vals),
        .hit_q   (mark_hit_o)
    );

    // R7
    hit_matches_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_hit_o[0] |-> (cnt_o == mark_vals[CNT_W-1:0])));
endmodule

// File: tb/tstamp_timer_tb.sv
module tstamp_timer_tb_top;
    localparam int W = 16;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bit_tick = 1'b0;
    logic           sof_pulse = 1'b0;
    logic           eof_pulse = 1'b0;
    logic           cap_at_eof = 1'b0;
    logic           freeze_en = 1'b0;
    logic           clr_pulse = 1'b0;
    logic           tt_mode = 1'b0;
    logic [N*W-1:0] mark_vals = '0;
    logic [W-1:0]   cnt_o, stamp_o;
    logic           frozen_o, wrap_o;
    logic [N-1:0]   mark_hit_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference state
    int           m_cnt = 0;
    int           m_stamp = 0;
    bit           m_frz = 0;
    bit           m_wrap = 0;
    bit [N-1:0]   m_hit = '0;

    always #4 clk = ~clk;

    tstamp_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sof_pulse(sof_pulse),
        .eof_pulse(eof_pulse), .cap_at_eof(cap_at_eof), .freeze_en(freeze_en),
        .clr_pulse(clr_pulse), .tt_mode(tt_mode), .mark_vals(mark_vals),
        .cnt_o(cnt_o), .stamp_o(stamp_o), .frozen_o(frozen_o), .wrap_o(wrap_o),
        .mark_hit_o(mark_hit_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // reference model, updated on each rising edge
    always @(posedge clk) begin
        bit upd;
        if (!rst_n) begin
            m_cnt = 0; m_stamp = 0; m_frz = 0; m_wrap = 0; m_hit = '0;
        end else begin
            upd = 0;
            m_wrap = 0;
            if (cap_at_eof ? eof_pulse : sof_pulse) m_stamp = m_cnt;
            if (clr_pulse) begin
                m_cnt = 0; m_frz = 0; upd = 1;
            end else if (bit_tick && !m_frz) begin
                if (m_cnt == 65535) begin
                    if (freeze_en) m_frz = 1;
                    else begin m_cnt = 0; m_wrap = 1; upd = 1; end
                end else begin
                    m_cnt = m_cnt + 1; upd = 1;
                end
            end
            for (int i = 0; i < N; i++)
                m_hit[i] = tt_mode && upd && (m_cnt == int'(mark_vals[i*W +: W]));
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(cnt_o) == m_cnt, "R2 count", cnt_o, m_cnt);
            chk(int'(stamp_o) == m_stamp, "R6 stamp", stamp_o, m_stamp);
            chk(frozen_o == m_frz, "R5 frozen", frozen_o, m_frz);
            chk(wrap_o == m_wrap, "R4 wrap", wrap_o, m_wrap);
            chk(mark_hit_o == m_hit, "R7 hits", mark_hit_o, m_hit);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            chk(1'b0, "watchdog", cycles, 190000);
            finish_up();
        end
    end

    initial begin
        mark_vals = {16'hFFFF, 16'd700, 16'd301, 16'd300, 16'd100, 16'd40, 16'd20, 16'd5};
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(cnt_o == 0 && stamp_o == 0 && !frozen_o && !wrap_o && mark_hit_o == 0,
            "R1 reset", {cnt_o, stamp_o}, 0);
        rst_n = 1'b1;
        tt_mode = 1'b1;

        // random mix of ticks, frame pulses, clears, modes
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            bit_tick   = ($urandom % 2) == 0;
            sof_pulse  = ($urandom % 10) == 0;
            eof_pulse  = ($urandom % 10) == 0;
            clr_pulse  = ($urandom % 400) == 0;
            freeze_en  = ($urandom % 2) == 0;
            if (k % 500 == 0) cap_at_eof = ~cap_at_eof;
        end

        // R8: time-triggered mode off silences hits while count crosses marks
        @(negedge clk);
        clr_pulse = 1'b1; bit_tick = 1'b0; sof_pulse = 1'b0; eof_pulse = 1'b0; tt_mode = 1'b0;
        @(negedge clk);
        clr_pulse = 1'b0;
        for (int k = 0; k < 120; k++) begin
            bit_tick = 1'b1;
            @(negedge clk);
            chk(mark_hit_o == 0, "R8 tt off", mark_hit_o, 0);
        end
        tt_mode = 1'b1;

        // R4/R5: saturate with freeze enabled
        clr_pulse = 1'b1; freeze_en = 1'b1;
        @(negedge clk);
        clr_pulse = 1'b0;
        bit_tick = 1'b1;
        repeat (65540) @(negedge clk);
        chk(frozen_o && cnt_o == 16'hFFFF, "R5 saturate", {frozen_o, cnt_o}, 32'h1FFFF);
        freeze_en = 1'b0;
        repeat (8) @(negedge clk);
        chk(frozen_o && cnt_o == 16'hFFFF, "R5 stays frozen", {frozen_o, cnt_o}, 32'h1FFFF);
        chk(mark_hit_o == 0, "R9 no repeat hit", mark_hit_o, 0);
        // R3: clear with a simultaneous tick while frozen
        clr_pulse = 1'b1;
        @(negedge clk);
        clr_pulse = 1'b0; bit_tick = 1'b0;
        chk(cnt_o == 0 && !frozen_o, "R3 clear", {frozen_o, cnt_o}, 0);
        @(negedge clk);
        chk(cnt_o == 0, "R2 hold without tick", cnt_o, 0);

        // R4: wrap with freeze disabled
        bit_tick = 1'b1;
        repeat (65540) @(negedge clk);
        chk(!frozen_o && cnt_o < 16'd10, "R4 wrapped", cnt_o, 4);

        // R6 ignored pulse: end-of-frame while start-of-frame is selected
        bit_tick = 1'b0; cap_at_eof = 1'b0; eof_pulse = 1'b1;
        @(negedge clk);
        eof_pulse = 1'b0;
        @(negedge clk);
        chk(int'(stamp_o) == m_stamp, "R6 unselected pulse", stamp_o, m_stamp);
        finish_up();
    end
endmodule